// File: doc/BRIEF.md
# Dual CPU Interrupt Generator

This block produces the interrupt outputs that a video controller presents to two processors. The main CPU receives two interrupt sources on one encoded level output. The frame (vertical) interrupt takes the higher level and the line (horizontal) interrupt takes the lower level. Each source keeps a pending bit. An enable input gates what the CPU sees, but the enable does not change the pending bit. The vertical pending bit also feeds the frame flag of the status register.

How a pending source is cleared depends on the display mode. In native mode, the CPU's interrupt-acknowledge strobe clears the source. That strobe carries no level, so the block has to decide which source was acknowledged. It assumes the CPU took every source that was visible at that moment. If both sources were visible, the horizontal one is dropped along with the vertical one. In legacy mode, the acknowledge strobe is ignored and only a status read clears pending state. A status read always clears the vertical source.

The block also drives a frame interrupt to a secondary sound CPU. This interrupt cannot be masked. It starts at vertical-blank start and lasts for a fixed number of line boundaries, which is one line by default. All outputs are registered. The line counter that generates the strobes lies outside the block.

Top module: `dual_irq_gen`

## Requirements
- R1: After a synchronous reset, `lvl_o` is 0, `vflag_o` is 0 and `sub_irq_o` is 0.
- R2: A `vblank_start_i` strobe sets vertical pending. `vflag_o` is 1 in the cycle after the strobe, whatever the enables are.
- R3: `lvl_o` encodes the visible source as follows: 2 for vertical, 1 for horizontal, 0 for none. Vertical wins when both are visible. A source is visible when it is pending and its enable is 1 at the clock edge.
- R4: In native mode (`legacy_i`=0), `iack_i` clears the visible horizontal source when it is the only one visible. `lvl_o` then returns to 0 one cycle later.
- R5: In native mode, `iack_i` clears every visible source. When both are visible, both are cleared, so the horizontal interrupt is lost.
- R6: In legacy mode (`legacy_i`=1), `iack_i` has no effect on either pending bit.
- R7: `stat_rd_i` clears vertical pending in both modes. It also clears horizontal pending in legacy mode only. In native mode it leaves horizontal pending unchanged.
- R8: When an event strobe and a clear of the same source fall in the same cycle, the source stays pending.
- R9: A pending source whose enable is 0 stays pending. It does not appear on `lvl_o`, and `iack_i` does not clear it. It appears once its enable returns to 1.
- R10: `sub_irq_o` rises in the cycle after `vblank_start_i`. It falls in the cycle after the SUB_LINES-th following `line_tick_i` strobe. No enable, acknowledge or status read affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_start_i | input | 1 | One-cycle strobe at vertical-blank start |
| hevent_i | input | 1 | One-cycle strobe for the line interrupt event |
| line_tick_i | input | 1 | One-cycle strobe at each line boundary |
| vint_en_i | input | 1 | Vertical interrupt enable |
| hint_en_i | input | 1 | Horizontal interrupt enable |
| legacy_i | input | 1 | 1 selects legacy mode, 0 selects native mode |
| iack_i | input | 1 | Interrupt-acknowledge strobe from the main CPU |
| stat_rd_i | input | 1 | Status register read strobe |
| lvl_o | output | 2 | Interrupt level to the main CPU (2 vertical, 1 horizontal, 0 none) |
| vflag_o | output | 1 | Vertical pending flag for the status register |
| sub_irq_o | output | 1 | Frame interrupt pulse to the secondary CPU |

## Verification
The assertions check the following on every cycle:
- The vertical flag follows a vertical-blank strobe.
- A status read drops the flag.
- Level 2 is never shown without the flag.
- An acknowledge in legacy mode leaves both pending bits alone.
- An acknowledge in native mode with both sources enabled empties the level.
- The secondary pulse only starts after a vertical-blank strobe.

The bench's scenarios show the rest. These are the attribution of an acknowledge when only a masked source is pending, and the mode-dependent reach of a status read. They also cover the rule that a new event wins over a clear in the same cycle, and the exact length of the secondary pulse in line ticks. A long sweep compares all three outputs against a cycle model built from the requirements.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_HORZ = 2'd1,
    LVL_VERT = 2'd2
  } irq_lvl_e;
endpackage

// File: rtl/dual_irq_pend.sv
// One pending bit; a set in the same cycle as a clear wins.
module dual_irq_pend (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o,
  output logic nxt_o
);
  assign nxt_o = set_i | (pend_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) pend_o <= 1'b0;
    else     pend_o <= nxt_o;
  end
endmodule

// File: rtl/dual_irq_sub.sv
// Unmaskable frame pulse lasting LINES line ticks.
module dual_irq_sub #(
  parameter int LINES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LINES + 1);
  localparam logic [CW-1:0] LOAD = CW'(LINES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)                     cnt_d = LOAD;
    else if (tick_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_o <= (cnt_d != '0);
    end
  end
endmodule

// File: rtl/dual_irq_gen.sv
module dual_irq_gen
  import dual_irq_pkg::*;
#(
  parameter int SUB_LINES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vblank_start_i,
  input  logic       hevent_i,
  input  logic       line_tick_i,
  input  logic       vint_en_i,
  input  logic       hint_en_i,
  input  logic       legacy_i,
  input  logic       iack_i,
  input  logic       stat_rd_i,
  output logic [1:0] lvl_o,
  output logic       vflag_o,
  output logic       sub_irq_o
);
  logic v_pend, v_nxt, h_pend, h_nxt;
  logic v_show, h_show, ack_ok, v_clr, h_clr;
  irq_lvl_e lvl_d;

  // An acknowledge takes every source the CPU can currently see.
  assign v_show = v_pend & vint_en_i;
  assign h_show = h_pend & hint_en_i;
  assign ack_ok = iack_i & ~legacy_i;
  assign v_clr  = stat_rd_i | (ack_ok & v_show);
  assign h_clr  = (stat_rd_i & legacy_i) | (ack_ok & h_show);

  dual_irq_pend u_v (
    .clk(clk), .rst(rst), .set_i(vblank_start_i), .clr_i(v_clr),
    .pend_o(v_pend), .nxt_o(v_nxt)
  );

  dual_irq_pend u_h (
    .clk(clk), .rst(rst), .set_i(hevent_i), .clr_i(h_clr),
    .pend_o(h_pend), .nxt_o(h_nxt)
  );

  always_comb begin
    if (v_nxt && vint_en_i)      lvl_d = LVL_VERT;
    else if (h_nxt && hint_en_i) lvl_d = LVL_HORZ;
    else                         lvl_d = LVL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_o <= LVL_NONE;
    else     lvl_o <= lvl_d;
  end

  assign vflag_o = v_pend;

  dual_irq_sub #(.LINES(SUB_LINES)) u_sub (
    .clk(clk), .rst(rst), .start_i(vblank_start_i), .tick_i(line_tick_i),
    .pulse_o(sub_irq_o)
  );
endmodule

// File: rtl/dual_irq_chk.sv
module dual_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       vblank_start_i,
  input logic       hevent_i,
  input logic       vint_en_i,
  input logic       hint_en_i,
  input logic       legacy_i,
  input logic       iack_i,
  input logic       stat_rd_i,
  input logic [1:0] lvl_o,
  input logic       vflag_o,
  input logic       sub_irq_o,
  input logic       h_pend
);
  // R2
  vflag_set_chk: assert property (@(posedge clk) disable iff (rst)
    vblank_start_i |=> vflag_o);

  // R7
  rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && !vblank_start_i) |=> !vflag_o);

  // R3
  vert_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_o == 2'd2) |-> vflag_o);

  // R6
  legacy_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (legacy_i && iack_i && !stat_rd_i && !vblank_start_i && !hevent_i)
      |=> ($stable(vflag_o) && $stable(h_pend)));

  // R5
  ack_both_chk: assert property (@(posedge clk) disable iff (rst)
    (!legacy_i && iack_i && vint_en_i && hint_en_i && !vblank_start_i && !hevent_i)
      |=> (lvl_o == 2'd0));

  // R10
  sub_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sub_irq_o) |-> $past(vblank_start_i));
endmodule

bind dual_irq_gen dual_irq_chk u_chk (
  .clk(clk), .rst(rst), .vblank_start_i(vblank_start_i), .hevent_i(hevent_i),
  .vint_en_i(vint_en_i), .hint_en_i(hint_en_i), .legacy_i(legacy_i),
  .iack_i(iack_i), .stat_rd_i(stat_rd_i), .lvl_o(lvl_o), .vflag_o(vflag_o),
  .sub_irq_o(sub_irq_o), .h_pend(h_pend)
);

// File: tb/dual_irq_gen_tb.sv
module dual_irq_gen_tb_top;
  localparam int LINES = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vb = 0, hev = 0, tick = 0, ven = 0, hen = 0, leg = 0, ack = 0, rd = 0;
  logic [1:0] lvl;
  logic vflag, sub;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_irq_gen #(.SUB_LINES(LINES)) dut_i (
    .clk(clk), .rst(rst), .vblank_start_i(vb), .hevent_i(hev), .line_tick_i(tick),
    .vint_en_i(ven), .hint_en_i(hen), .legacy_i(leg), .iack_i(ack),
    .stat_rd_i(rd), .lvl_o(lvl), .vflag_o(vflag), .sub_irq_o(sub)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    vb = 0; hev = 0; tick = 0; ack = 0; rd = 0;
  endtask

  // model state
  int mv, mh, mc;

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 0;
    step();
    chk("R1 lvl", lvl, 0); chk("R1 vflag", vflag, 0); chk("R1 sub", sub, 0);

    ven = 1; hen = 1; vb = 1; step();
    chk("R2 vflag", vflag, 1); chk("R3 lvl vert", lvl, 2); chk("R10 sub rise", sub, 1);
    tick = 1; step();
    chk("R10 sub fall", sub, 0); chk("R3 lvl held", lvl, 2);
    hev = 1; step();
    chk("R3 vert priority", lvl, 2);
    ack = 1; step();
    chk("R5 both lost lvl", lvl, 0); chk("R5 vflag", vflag, 0);

    hev = 1; step();
    chk("R3 horz", lvl, 1);
    ack = 1; step();
    chk("R4 horz acked", lvl, 0);

    hen = 0; hev = 1; step();
    chk("R9 gated", lvl, 0);
    ack = 1; step();
    chk("R9 masked after ack", lvl, 0);
    hen = 1; step();
    chk("R9 kept pending", lvl, 1);

    rd = 1; step();
    chk("R7 native rd keeps horz", lvl, 1);
    vb = 1; rd = 1; step();
    chk("R8 set wins", vflag, 1); chk("R8 lvl", lvl, 2);

    leg = 1; ack = 1; step();
    chk("R6 legacy ack vflag", vflag, 1); chk("R6 legacy ack lvl", lvl, 2);
    ven = 0; step();
    chk("R6 horz still pending", lvl, 1);
    ven = 1; rd = 1; step();
    chk("R7 legacy rd vflag", vflag, 0); chk("R7 legacy rd lvl", lvl, 0);

    ven = 0; hen = 0; leg = 0; vb = 1; step();
    chk("R10 unmasked sub", sub, 1); chk("R9 vflag masked", vflag, 1); chk("R9 lvl masked", lvl, 0);
    ack = 1; rd = 1; step();
    chk("R10 sub ignores ack/rd", sub, 1);
    tick = 1; step();
    chk("R10 sub end", sub, 0);

    // sweep against a cycle model
    rst = 1; step(); rst = 0;
    mv = 0; mh = 0; mc = 0;
    for (int k = 0; k < 4096; k++) begin
      logic [7:0] p;
      int vs, hs, ao, nv, nh, el;
      p = 8'((k * 37) ^ (k >> 4) ^ (k * 5 >> 2));
      vb = p[0] & p[5]; hev = p[1]; tick = p[2]; ven = p[3]; hen = p[4];
      leg = p[6]; ack = p[7]; rd = p[5] & p[2] & ~p[0];
      vs = mv & ven; hs = mh & hen; ao = ack & ~leg;
      nv = (vb || (mv && !(rd || (ao && vs)))) ? 1 : 0;
      nh = (hev || (mh && !((rd && leg) || (ao && hs)))) ? 1 : 0;
      el = (nv && ven) ? 2 : ((nh && hen) ? 1 : 0);
      if (vb) mc = LINES;
      else if (tick && mc > 0) mc = mc - 1;
      mv = nv; mh = nh;
      step();
      chk("R3 sweep lvl", lvl, el);
      chk("R2 sweep vflag", vflag, mv);
      chk("R10 sweep sub", sub, (mc != 0) ? 1 : 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule